// File: doc/BRIEF.md
# Address-Space-Tagged Translation Buffer

This block holds recently used virtual-to-physical page translations in a small, fully associative array. Each slot stores a virtual page number tag, a physical page number, one read-enable bit and one write-enable bit per processor mode, and a fault-on-read and a fault-on-write flag. It also stores a global flag and an 8-bit address-space number (ASN). A lookup presents a page number and the current ASN. In the same cycle the block returns a hit flag and the fields of the matching slot. No page-table walk and no permission decision happen here. The consumer interprets the returned masks and flags.

New translations enter through a valid/ready insert channel. An insert is taken on a rising edge where `ins_valid` and `ins_ready` are both high. It is written into the slot named by a single rotating replacement pointer, whether or not that slot holds a live entry. `ins_ready` is low in any cycle where an invalidate command is asserted. A producer that sees ready low must hold its entry and present it again later. Three invalidate commands each act in one cycle: drop everything, drop every non-global entry, and drop the entries that match one page number under one ASN. When more than one invalidate command is asserted in the same cycle, the block drops the union of the entries that each command names.

The entry count is the parameter `ENTRIES`. Typical settings are 48 for an instruction-side instance and 64 for a data-side instance.

Top module: `xlat_cam`

## Requirements
- R1: A lookup hits only on a valid slot whose tag equals `lk_vpn` and which either has its global flag set or holds an ASN equal to `lk_asn`.
- R2: The lookup is combinational. On a miss, `lk_hit` is 0 and every returned field is 0.
- R3: When several valid slots match a lookup, the fields of the lowest-numbered slot are returned.
- R4: An accepted insert writes the slot at the replacement pointer. It replaces any live entry there, marks the slot valid with `ins_vpn` as its tag, and the pointer then advances by one.
- R5: The replacement pointer steps from `ENTRIES-1` back to slot 0.
- R6: `flush_all` invalidates every slot and returns the replacement pointer to slot 0 on the next edge.
- R7: `flush_proc` invalidates every slot whose global flag is 0 and leaves global slots valid.
- R8: `flush_addr` invalidates every valid slot that matches `flush_vpn` and `flush_asn` under the rule of R1, and only those slots.
- R9: `ins_ready` is 0 in any cycle with an invalidate command asserted. An insert offered in that cycle is not taken, and the pointer does not advance for it.
- R10: After reset no slot is valid, the pointer is at slot 0, and `ins_ready` is 1.
- R11: On a hit, `lk_ppn`, `lk_rd_en`, `lk_wr_en`, `lk_flt_rd`, `lk_flt_wr` and `lk_global` equal the values inserted into the matching slot. Bit m of each enable mask belongs to processor mode m.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| lk_vpn | input | 30 | Lookup virtual page number |
| lk_asn | input | 8 | Current address-space number |
| lk_hit | output | 1 | Lookup matched a slot |
| lk_ppn | output | 28 | Physical page number of the match |
| lk_rd_en | output | 4 | Per-mode read enables of the match |
| lk_wr_en | output | 4 | Per-mode write enables of the match |
| lk_flt_rd | output | 1 | Fault-on-read flag of the match |
| lk_flt_wr | output | 1 | Fault-on-write flag of the match |
| lk_global | output | 1 | Global flag of the match |
| ins_valid | input | 1 | Insert entry offered |
| ins_ready | output | 1 | Insert can be taken this cycle |
| ins_vpn | input | 30 | Tag of the new entry |
| ins_ppn | input | 28 | Physical page number of the new entry |
| ins_rd_en | input | 4 | Per-mode read enables of the new entry |
| ins_wr_en | input | 4 | Per-mode write enables of the new entry |
| ins_flt_rd | input | 1 | Fault-on-read flag of the new entry |
| ins_flt_wr | input | 1 | Fault-on-write flag of the new entry |
| ins_global | input | 1 | Global flag of the new entry |
| ins_asn | input | 8 | ASN of the new entry |
| flush_all | input | 1 | Invalidate all slots and reset the pointer |
| flush_proc | input | 1 | Invalidate all non-global slots |
| flush_addr | input | 1 | Invalidate slots matching flush_vpn/flush_asn |
| flush_vpn | input | 30 | Page number for flush_addr |
| flush_asn | input | 8 | ASN for flush_addr |

## Verification
The hardest state to reach from the ports is an overwrite of a slot that is still live. The replacement pointer cannot be read, so the bench has to walk it all the way round. With a four-slot instance, the bench fills every slot, invalidates part of the array, and inserts three more entries. The third of these lands on an older global entry that is still valid, and a lookup that used to hit on that entry now misses. That miss shows both the overwrite and the wrap. The lowest-slot rule needs two legal matches at once. The bench creates them with one non-global entry and one global entry that share a tag, and it presents the ASN of the non-global entry.

// File: rtl/xtb_pkg.sv
package xtb_pkg;
  localparam int VPN_W = 30;
  localparam int PPN_W = 28;
  localparam int ASN_W = 8;
  localparam int MODES = 4;

  typedef struct packed {
    logic [PPN_W-1:0] ppn;
    logic [MODES-1:0] rd_en;
    logic [MODES-1:0] wr_en;
    logic             flt_rd;
    logic             flt_wr;
    logic             glob;
    logic [ASN_W-1:0] asn;
  } xtb_payload_t;
endpackage

// File: rtl/xtb_match.sv
module xtb_match
  import xtb_pkg::*;
#(
  parameter int ENTRIES = 48
) (
  input  logic [ENTRIES-1:0]            valid,
  input  logic [ENTRIES-1:0][VPN_W-1:0] tags,
  input  logic [ENTRIES-1:0]            glob,
  input  logic [ENTRIES-1:0][ASN_W-1:0] asns,
  input  logic [VPN_W-1:0]              key_vpn,
  input  logic [ASN_W-1:0]              key_asn,
  output logic [ENTRIES-1:0]            hits
);
  for (genvar i = 0; i < ENTRIES; i++) begin : g_cmp
    assign hits[i] = valid[i] && (tags[i] == key_vpn) &&
                     (glob[i] || (asns[i] == key_asn));
  end
endmodule

// File: rtl/xtb_pick.sv
module xtb_pick #(
  parameter int ENTRIES = 48,
  localparam int IDX_W  = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
  input  logic [ENTRIES-1:0] req,
  output logic               any,
  output logic [IDX_W-1:0]   idx
);
  always_comb begin
    any = 1'b0;
    idx = '0;
    for (int k = ENTRIES - 1; k >= 0; k--) begin
      if (req[k]) begin
        any = 1'b1;
        idx = IDX_W'(k);
      end
    end
  end
endmodule

// File: rtl/xtb_store.sv
module xtb_store
  import xtb_pkg::*;
#(
  parameter int ENTRIES = 48,
  localparam int IDX_W  = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          wr_fire,
  input  logic [VPN_W-1:0]              wr_vpn,
  input  xtb_payload_t                  wr_data,
  input  logic                          clr_all,
  input  logic [ENTRIES-1:0]            clr_mask,
  output logic [ENTRIES-1:0]            valid_q,
  output logic [ENTRIES-1:0][VPN_W-1:0] tag_q,
  output xtb_payload_t [ENTRIES-1:0]    data_q,
  output logic [IDX_W-1:0]              ptr_q
);
  localparam logic [IDX_W-1:0] LAST = IDX_W'(ENTRIES - 1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                 ptr_q <= '0;
    else if (clr_all)           ptr_q <= '0;
    else if (wr_fire)           ptr_q <= (ptr_q == LAST) ? '0 : ptr_q + 1'b1;
  end

  for (genvar i = 0; i < ENTRIES; i++) begin : g_slot
    logic take;
    assign take = wr_fire && (ptr_q == IDX_W'(i));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                      valid_q[i] <= 1'b0;
      else if (clr_all || clr_mask[i]) valid_q[i] <= 1'b0;
      else if (take)                   valid_q[i] <= 1'b1;
    end

    always_ff @(posedge clk) begin
      if (take) begin
        tag_q[i]  <= wr_vpn;
        data_q[i] <= wr_data;
      end
    end
  end

  // R5: pointer steps by one and wraps at the last slot
  p_ptr_step_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_fire && !clr_all) |=>
      (ptr_q == (($past(ptr_q) == LAST) ? '0 : $past(ptr_q) + 1'b1)));

  // R6: flush-all empties the array and rewinds the pointer
  p_flush_all_r6: assert property (@(posedge clk) disable iff (!rst_n)
    clr_all |=> ((valid_q == '0) && (ptr_q == '0)));

  // R4: a write marks its slot live unless cleared in the same cycle
  p_write_live_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_fire && !clr_all && !clr_mask[ptr_q]) |=> valid_q[$past(ptr_q)]);
endmodule

// File: rtl/xlat_cam.sv
module xlat_cam
  import xtb_pkg::*;
#(
  parameter int ENTRIES = 48,
  localparam int IDX_W  = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [29:0]      lk_vpn,
  input  logic [7:0]       lk_asn,
  output logic             lk_hit,
  output logic [27:0]      lk_ppn,
  output logic [3:0]       lk_rd_en,
  output logic [3:0]       lk_wr_en,
  output logic             lk_flt_rd,
  output logic             lk_flt_wr,
  output logic             lk_global,
  input  logic             ins_valid,
  output logic             ins_ready,
  input  logic [29:0]      ins_vpn,
  input  logic [27:0]      ins_ppn,
  input  logic [3:0]       ins_rd_en,
  input  logic [3:0]       ins_wr_en,
  input  logic             ins_flt_rd,
  input  logic             ins_flt_wr,
  input  logic             ins_global,
  input  logic [7:0]       ins_asn,
  input  logic             flush_all,
  input  logic             flush_proc,
  input  logic             flush_addr,
  input  logic [29:0]      flush_vpn,
  input  logic [7:0]       flush_asn
);
  logic [ENTRIES-1:0]            valid_q;
  logic [ENTRIES-1:0][VPN_W-1:0] tag_q;
  xtb_payload_t [ENTRIES-1:0]    data_q;
  logic [IDX_W-1:0]              ptr_q;
  logic [ENTRIES-1:0]            glob_v;
  logic [ENTRIES-1:0][ASN_W-1:0] asn_v;
  logic [ENTRIES-1:0]            lk_match, fl_match, clr_mask;
  logic [IDX_W-1:0]              lk_idx;
  logic                          any_flush, wr_fire;
  xtb_payload_t                  wr_data, sel;

  for (genvar i = 0; i < ENTRIES; i++) begin : g_split
    assign glob_v[i] = data_q[i].glob;
    assign asn_v[i]  = data_q[i].asn;
  end

  assign any_flush = flush_all | flush_proc | flush_addr;
  assign ins_ready = ~any_flush;
  assign wr_fire   = ins_valid & ins_ready;
  assign clr_mask  = ({ENTRIES{flush_proc}} & ~glob_v) |
                     ({ENTRIES{flush_addr}} & fl_match);

  always_comb begin
    wr_data        = '0;
    wr_data.ppn    = ins_ppn;
    wr_data.rd_en  = ins_rd_en;
    wr_data.wr_en  = ins_wr_en;
    wr_data.flt_rd = ins_flt_rd;
    wr_data.flt_wr = ins_flt_wr;
    wr_data.glob   = ins_global;
    wr_data.asn    = ins_asn;
  end

  xtb_store #(.ENTRIES(ENTRIES)) u_store (
    .clk(clk), .rst_n(rst_n), .wr_fire(wr_fire), .wr_vpn(ins_vpn),
    .wr_data(wr_data), .clr_all(flush_all), .clr_mask(clr_mask),
    .valid_q(valid_q), .tag_q(tag_q), .data_q(data_q), .ptr_q(ptr_q)
  );

  xtb_match #(.ENTRIES(ENTRIES)) u_lk_match (
    .valid(valid_q), .tags(tag_q), .glob(glob_v), .asns(asn_v),
    .key_vpn(lk_vpn), .key_asn(lk_asn), .hits(lk_match)
  );

  xtb_match #(.ENTRIES(ENTRIES)) u_fl_match (
    .valid(valid_q), .tags(tag_q), .glob(glob_v), .asns(asn_v),
    .key_vpn(flush_vpn), .key_asn(flush_asn), .hits(fl_match)
  );

  xtb_pick #(.ENTRIES(ENTRIES)) u_pick (
    .req(lk_match), .any(lk_hit), .idx(lk_idx)
  );

  assign sel       = lk_hit ? data_q[lk_idx] : '0;
  assign lk_ppn    = sel.ppn;
  assign lk_rd_en  = sel.rd_en;
  assign lk_wr_en  = sel.wr_en;
  assign lk_flt_rd = sel.flt_rd;
  assign lk_flt_wr = sel.flt_wr;
  assign lk_global = sel.glob;

  // R1: a reported hit always comes from a live slot carrying the tag
  p_hit_live_r1: assert property (@(posedge clk) disable iff (!rst_n)
    lk_hit |-> (valid_q[lk_idx] && (tag_q[lk_idx] == lk_vpn)));

  // R9: selective flushes never move the pointer, so a blocked insert is dropped
  p_no_step_on_flush_r9: assert property (@(posedge clk) disable iff (!rst_n)
    ((flush_proc || flush_addr) && !flush_all) |=> (ptr_q == $past(ptr_q)));

  // R7: after flush-process only global slots remain live
  p_proc_spares_global_r7: assert property (@(posedge clk) disable iff (!rst_n)
    flush_proc |=> ((valid_q & ~glob_v) == '0));

  // R8: after flush-address nothing still matches the flushed key
  p_addr_gone_r8: assert property (@(posedge clk) disable iff (!rst_n)
    flush_addr |=> (fl_match & $past(fl_match)) == '0);
endmodule

// File: tb/tb_xlat_cam.sv
module tb_xlat_cam;
  localparam int N = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #5 clk = ~clk;

  logic [29:0] lk_vpn = '0;
  logic [7:0]  lk_asn = '0;
  logic        lk_hit, lk_flt_rd, lk_flt_wr, lk_global, ins_ready;
  logic [27:0] lk_ppn;
  logic [3:0]  lk_rd_en, lk_wr_en;
  logic        ins_valid = 1'b0;
  logic [29:0] ins_vpn = '0;
  logic [27:0] ins_ppn = '0;
  logic [3:0]  ins_rd_en = '0, ins_wr_en = '0;
  logic        ins_flt_rd = 1'b0, ins_flt_wr = 1'b0, ins_global = 1'b0;
  logic [7:0]  ins_asn = '0;
  logic        flush_all = 1'b0, flush_proc = 1'b0, flush_addr = 1'b0;
  logic [29:0] flush_vpn = '0;
  logic [7:0]  flush_asn = '0;

  xlat_cam #(.ENTRIES(N)) dut (
    .clk(clk), .rst_n(rst_n), .lk_vpn(lk_vpn), .lk_asn(lk_asn),
    .lk_hit(lk_hit), .lk_ppn(lk_ppn), .lk_rd_en(lk_rd_en), .lk_wr_en(lk_wr_en),
    .lk_flt_rd(lk_flt_rd), .lk_flt_wr(lk_flt_wr), .lk_global(lk_global),
    .ins_valid(ins_valid), .ins_ready(ins_ready), .ins_vpn(ins_vpn),
    .ins_ppn(ins_ppn), .ins_rd_en(ins_rd_en), .ins_wr_en(ins_wr_en),
    .ins_flt_rd(ins_flt_rd), .ins_flt_wr(ins_flt_wr), .ins_global(ins_global),
    .ins_asn(ins_asn), .flush_all(flush_all), .flush_proc(flush_proc),
    .flush_addr(flush_addr), .flush_vpn(flush_vpn), .flush_asn(flush_asn)
  );

  typedef struct {
    logic [40:0] vec;  // {hit, ppn, rd, wr, frd, fwr, glob, ready}
    string       req;
  } exp_t;

  exp_t q[$];
  int   n_vec = 0;
  int   n_bad = 0;
  bit   done  = 1'b0;

  // monitor: samples 3 ns after each falling edge, well before the next rising edge
  always begin
    @(negedge clk);
    #3;
    if (q.size() > 0) begin
      exp_t e;
      logic [40:0] act;
      e   = q.pop_front();
      act = {lk_hit, lk_ppn, lk_rd_en, lk_wr_en, lk_flt_rd, lk_flt_wr, lk_global, ins_ready};
      n_vec++;
      if (act !== e.vec) begin
        n_bad++;
        $display("FAIL %s: actual %h expected %h", e.req, act, e.vec);
      end
    end
  end

  task automatic idle_inputs();
    ins_valid = 1'b0; flush_all = 1'b0; flush_proc = 1'b0; flush_addr = 1'b0;
  endtask

  task automatic insert(input logic [29:0] v, input logic [27:0] p, input logic [3:0] rd,
                        input logic [3:0] wr, input logic fr, input logic fw,
                        input logic g, input logic [7:0] a);
    @(negedge clk);
    idle_inputs();
    ins_valid = 1'b1; ins_vpn = v; ins_ppn = p; ins_rd_en = rd; ins_wr_en = wr;
    ins_flt_rd = fr; ins_flt_wr = fw; ins_global = g; ins_asn = a;
  endtask

  task automatic flush(input logic fa, input logic fp, input logic fd,
                       input logic [29:0] v, input logic [7:0] a);
    @(negedge clk);
    idle_inputs();
    flush_all = fa; flush_proc = fp; flush_addr = fd; flush_vpn = v; flush_asn = a;
  endtask

  task automatic expect_now(input logic [29:0] v, input logic [7:0] a, input logic h,
                            input logic [27:0] p, input logic [3:0] rd, input logic [3:0] wr,
                            input logic fr, input logic fw, input logic g,
                            input logic rdy, input string req);
    exp_t e;
    lk_vpn = v; lk_asn = a;
    e.vec = h ? {1'b1, p, rd, wr, fr, fw, g, rdy} : {40'b0, rdy};
    e.req = req;
    q.push_back(e);
  endtask

  task automatic probe(input logic [29:0] v, input logic [7:0] a, input logic h,
                       input logic [27:0] p, input logic [3:0] rd, input logic [3:0] wr,
                       input logic fr, input logic fw, input logic g, input string req);
    @(negedge clk);
    idle_inputs();
    expect_now(v, a, h, p, rd, wr, fr, fw, g, 1'b1, req);
  endtask

  task automatic probe_miss(input logic [29:0] v, input logic [7:0] a, input string req);
    probe(v, a, 1'b0, '0, '0, '0, 1'b0, 1'b0, 1'b0, req);
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    probe_miss(30'h10, 8'd1, "R10 empty after reset, ready high");

    // slot 0: non-global, ASN 1
    insert(30'h10, 28'h100, 4'b0011, 4'b0001, 1'b0, 1'b1, 1'b0, 8'd1);
    probe(30'h10, 8'd1, 1'b1, 28'h100, 4'b0011, 4'b0001, 1'b0, 1'b1, 1'b0, "R1 R11 hit own ASN");
    probe_miss(30'h10, 8'd2, "R1 ASN mismatch");
    probe_miss(30'h11, 8'd1, "R2 tag mismatch gives zero fields");

    // slot 1: global, ASN 3
    insert(30'h20, 28'h200, 4'b1111, 4'b0000, 1'b1, 1'b0, 1'b1, 8'd3);
    probe(30'h20, 8'd7, 1'b1, 28'h200, 4'b1111, 4'b0000, 1'b1, 1'b0, 1'b1, "R1 global ignores ASN");

    // slot 2: global, same tag as slot 0
    insert(30'h10, 28'h300, 4'b0101, 4'b0101, 1'b0, 1'b0, 1'b1, 8'd9);
    probe(30'h10, 8'd1, 1'b1, 28'h100, 4'b0011, 4'b0001, 1'b0, 1'b1, 1'b0, "R3 lowest slot wins");
    probe(30'h10, 8'd5, 1'b1, 28'h300, 4'b0101, 4'b0101, 1'b0, 1'b0, 1'b1, "R1 only global matches");

    flush(1'b0, 1'b1, 1'b0, '0, '0);
    probe(30'h10, 8'd1, 1'b1, 28'h300, 4'b0101, 4'b0101, 1'b0, 1'b0, 1'b1, "R7 non-global dropped");
    probe(30'h20, 8'd0, 1'b1, 28'h200, 4'b1111, 4'b0000, 1'b1, 1'b0, 1'b1, "R7 global kept");

    flush(1'b0, 1'b0, 1'b1, 30'h20, 8'd0);
    probe_miss(30'h20, 8'd3, "R8 global entry flushed by address");

    // slot 3: non-global, ASN 6
    insert(30'h40, 28'h400, 4'b0001, 4'b0001, 1'b0, 1'b0, 1'b0, 8'd6);
    flush(1'b0, 1'b0, 1'b1, 30'h40, 8'd7);
    probe(30'h40, 8'd6, 1'b1, 28'h400, 4'b0001, 4'b0001, 1'b0, 1'b0, 1'b0, "R8 other ASN spared");
    flush(1'b0, 1'b0, 1'b1, 30'h40, 8'd6);
    probe_miss(30'h40, 8'd6, "R8 matching ASN flushed");

    // pointer wrapped to 0: E->0, F->1, G->2 overwrites live global slot 2
    insert(30'h50, 28'h500, 4'b0010, 4'b0010, 1'b0, 1'b0, 1'b0, 8'd1);
    insert(30'h60, 28'h600, 4'b0010, 4'b0010, 1'b0, 1'b0, 1'b0, 8'd1);
    insert(30'h70, 28'h700, 4'b1000, 4'b0100, 1'b1, 1'b1, 1'b0, 8'd1);
    probe_miss(30'h10, 8'd5, "R4 R5 live slot overwritten after wrap");
    probe(30'h70, 8'd1, 1'b1, 28'h700, 4'b1000, 4'b0100, 1'b1, 1'b1, 1'b0, "R4 R11 new entry");
    probe(30'h50, 8'd1, 1'b1, 28'h500, 4'b0010, 4'b0010, 1'b0, 1'b0, 1'b0, "R5 wrapped slot 0");

    // flush-all and insert together
    @(negedge clk);
    idle_inputs();
    flush_all = 1'b1;
    ins_valid = 1'b1; ins_vpn = 30'h80; ins_ppn = 28'h800; ins_global = 1'b1; ins_asn = 8'd1;
    expect_now(30'h70, 8'd1, 1'b1, 28'h700, 4'b1000, 4'b0100, 1'b1, 1'b1, 1'b0, 1'b0,
               "R9 ready low during flush");
    probe_miss(30'h70, 8'd1, "R6 all slots cleared");
    probe_miss(30'h50, 8'd1, "R6 slot 0 cleared");
    probe_miss(30'h80, 8'd1, "R9 insert during flush not taken");

    insert(30'h80, 28'h800, 4'b0100, 4'b1000, 1'b0, 1'b1, 1'b1, 8'd2);
    probe(30'h80, 8'd4, 1'b1, 28'h800, 4'b0100, 4'b1000, 1'b0, 1'b1, 1'b1, "R9 insert accepted after flush");

    @(negedge clk);
    idle_inputs();
    repeat (2) @(negedge clk);
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule